// File: doc/BRIEF.md
# Two-Wire Slave Front End with Switchable Device Address

This block sits between an open-drain two-wire serial bus (I2C-compatible) and a small byte-addressed register space. It samples the bus clock and data lines through synchronisers running on a system clock. The system clock must be at least sixteen times faster than the bus clock. The block detects start, repeated start and stop conditions and decodes the device-address byte. It acknowledges bytes and drives read data by pulling the data line low. A register-address byte loads an internal pointer. Data bytes that follow are written through a single-cycle strobe. Reads fetch a byte combinationally from the register space through a single-cycle request.

An address-select input chooses the 7-bit device identity. When the input is low, the identity is a fixed constant. When it is high, the identity is the upper seven bits of a stored byte that the surrounding logic supplies. Writes advance the pointer only inside an aligned row of 2^PAGE_W bytes, so extra bytes wrap to the start of the row. Reads advance the pointer through the whole space and roll over at the top. While a busy input is high, for example during a nonvolatile commit, the block refuses its own address. A master can therefore poll until the storage is ready.

Top module: `i2cps_slave`

## Requirements
- R1: With addr_sel low, the byte 0xA2 (device 0x51, write) after a start is acknowledged. The block acknowledges by driving sda_oe high during the ninth bus clock.
- R2: With addr_sel high, the device identity is stored_addr[7:1], and stored_addr[0] does not affect matching. In this mode, 0xA2 is not acknowledged when the stored identity differs from 0x51.
- R3: After a device byte that does not match, the block acknowledges nothing and raises no write strobe until the next start.
- R4: In a write, the byte after the device byte loads the pointer. Each following data byte produces one wr_en pulse, with reg_addr set to the pointer and wr_data set to the byte.
- R5: After each written byte, the pointer advances by one inside its aligned 2-byte row. A third byte in a row therefore lands on the row's first byte again, and a write starting at an odd address continues at the even address below it.
- R6: A read (device byte with bit 0 = 1) returns bytes starting at the current pointer, most significant bit first. The pointer increases by one after each byte, so a register-address-only write followed by a repeated start positions the read.
- R7: When the master answers a read byte with a 1 (NACK), the block releases the data line and sends nothing more until the next start.
- R8: During reads the pointer rolls over from 0xFF to 0x00.
- R9: While busy is high at the end of the device byte, the address is not acknowledged and the transaction is ignored.
- R10: During reset and until the first start condition, sda_oe, wr_en and rd_en stay low.
- R11: sda_oe changes only while the bus clock is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus clock rate |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| addr_sel | input | 1 | 0: fixed device identity; 1: identity from stored_addr |
| stored_addr | input | 8 | Stored identity byte; bits 7:1 are used |
| busy | input | 1 | Refuse the device address while high |
| rd_data | input | 8 | Register byte at reg_addr, valid in the same cycle |
| sda_oe | output | 1 | 1 pulls the data line low |
| wr_en | output | 1 | One-cycle register write strobe |
| rd_en | output | 1 | One-cycle register read request |
| reg_addr | output | AW | Register pointer |
| wr_data | output | 8 | Byte to write with wr_en |

## Verification
The bench uses the default parameters: an 8-bit pointer, 2-byte rows, the stored-identity variant, fixed identity 0x51 and two synchroniser stages. With the 8-bit pointer, a read can cross from 0xFF to 0x00 within two bytes. The 1-bit row lets an odd start address and a third-byte overwrite show up after only a few bytes. Because the stored-identity variant is built in, the bench can flip the address source mid-run and show that stored bit 0 is ignored.

// File: rtl/i2cps_pkg.sv
package i2cps_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_RX,
      ST_ACK_WAIT,
      ST_ACK,
      ST_TX,
      ST_MACK,
      ST_MACK_HI
   } state_t;

   typedef enum logic [1:0] {
      RX_DEV,
      RX_REG,
      RX_DATA
   } rx_kind_t;
endpackage

// File: rtl/i2cps_sync.sv
module i2cps_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic din,
   output logic lvl,
   output logic rise,
   output logic fall
);
   logic [STAGES-1:0] pipe;
   logic              prev;

   initial assert (STAGES >= 2) else $error("i2cps_sync: STAGES must be at least 2");

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pipe <= '1;
         prev <= 1'b1;
      end else begin
         pipe <= {pipe[STAGES-2:0], din};
         prev <= pipe[STAGES-1];
      end
   end

   assign lvl  = pipe[STAGES-1];
   assign rise = lvl & ~prev;
   assign fall = ~lvl & prev;
endmodule

// File: rtl/i2cps_addr_match.sv
module i2cps_addr_match #(
   parameter logic [6:0] FIXED_ADDR = 7'h51,
   parameter bit         USE_STORED = 1'b1
) (
   input  logic       addr_sel,
   input  logic [7:0] stored_addr,
   input  logic [7:0] byte_in,
   output logic       hit
);
   localparam logic [7:0] FIXED_BYTE = {FIXED_ADDR, 1'b0};

   logic hit_fixed;
   assign hit_fixed = ((byte_in ^ FIXED_BYTE) & 8'hFE) == 8'h00;

   generate
      if (USE_STORED) begin : g_switch
         logic hit_stored;
         assign hit_stored = ((byte_in ^ stored_addr) & 8'hFE) == 8'h00;
         assign hit = addr_sel ? hit_stored : hit_fixed;
      end else begin : g_fixed
         assign hit = hit_fixed;
      end
   endgenerate
endmodule

// File: rtl/i2cps_ptr.sv
module i2cps_ptr #(
   parameter int AW     = 8,
   parameter int PAGE_W = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] load_val,
   input  logic          wr_step,
   input  logic          rd_step,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] next_rd;
   logic [AW-1:0] next_wr;

   initial assert (PAGE_W >= 1) else $error("i2cps_ptr: PAGE_W must be at least 1");

   assign next_rd = ptr + AW'(1);

   generate
      if (PAGE_W >= AW) begin : g_whole
         assign next_wr = next_rd;
      end else begin : g_row
         logic [PAGE_W-1:0] low_inc;
         assign low_inc = ptr[PAGE_W-1:0] + PAGE_W'(1);
         assign next_wr = {ptr[AW-1:PAGE_W], low_inc};
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (load)    ptr <= load_val;
      else if (wr_step) ptr <= next_wr;
      else if (rd_step) ptr <= next_rd;
   end
endmodule

// File: rtl/i2cps_slave.sv
module i2cps_slave
   import i2cps_pkg::*;
#(
   parameter int         AW          = 8,
   parameter int         PAGE_W      = 1,
   parameter int         SYNC_STAGES = 2,
   parameter logic [6:0] FIXED_ADDR  = 7'h51,
   parameter bit         USE_STORED  = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scl_i,
   input  logic          sda_i,
   input  logic          addr_sel,
   input  logic [7:0]    stored_addr,
   input  logic          busy,
   input  logic [7:0]    rd_data,
   output logic          sda_oe,
   output logic          wr_en,
   output logic          rd_en,
   output logic [AW-1:0] reg_addr,
   output logic [7:0]    wr_data
);
   localparam int BITS = 8;
   localparam int CW   = $clog2(BITS + 1);

   initial assert (AW >= 1 && AW <= 8) else $error("i2cps_slave: AW must be 1..8");

   state_t        state;
   rx_kind_t      kind;
   logic          to_tx;
   logic [7:0]    shreg;
   logic [CW-1:0] bitcnt;

   logic scl_l, scl_r, scl_f;
   logic sda_l, sda_r, sda_f;
   logic start_c, stop_c, last_bit, hit;
   logic [7:0] byte_next;
   logic ptr_load;

   i2cps_sync #(.STAGES(SYNC_STAGES)) u_scl (
      .clk(clk), .rst_n(rst_n), .din(scl_i),
      .lvl(scl_l), .rise(scl_r), .fall(scl_f)
   );

   i2cps_sync #(.STAGES(SYNC_STAGES)) u_sda (
      .clk(clk), .rst_n(rst_n), .din(sda_i),
      .lvl(sda_l), .rise(sda_r), .fall(sda_f)
   );

   assign start_c   = scl_l & sda_f;
   assign stop_c    = scl_l & sda_r;
   assign byte_next = {shreg[6:0], sda_l};
   assign last_bit  = (bitcnt == CW'(BITS - 1));

   i2cps_addr_match #(.FIXED_ADDR(FIXED_ADDR), .USE_STORED(USE_STORED)) u_match (
      .addr_sel(addr_sel), .stored_addr(stored_addr),
      .byte_in(byte_next), .hit(hit)
   );

   // strobes toward the register space
   assign ptr_load = (state == ST_RX) && (kind == RX_REG) && scl_r && last_bit;
   assign wr_en    = (state == ST_RX) && (kind == RX_DATA) && scl_r && last_bit;
   assign wr_data  = byte_next;
   assign rd_en    = scl_f && (((state == ST_ACK) && to_tx) || (state == ST_MACK_HI));

   i2cps_ptr #(.AW(AW), .PAGE_W(PAGE_W)) u_ptr (
      .clk(clk), .rst_n(rst_n),
      .load(ptr_load), .load_val(byte_next[AW-1:0]),
      .wr_step(wr_en), .rd_step(rd_en),
      .ptr(reg_addr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         kind   <= RX_DEV;
         to_tx  <= 1'b0;
         shreg  <= '0;
         bitcnt <= '0;
      end else if (start_c) begin
         state  <= ST_RX;
         kind   <= RX_DEV;
         bitcnt <= '0;
      end else if (stop_c) begin
         state <= ST_IDLE;
      end else begin
         case (state)
            ST_RX: begin
               if (scl_r) begin
                  shreg  <= byte_next;
                  bitcnt <= bitcnt + CW'(1);
                  if (last_bit) begin
                     case (kind)
                        RX_DEV: begin
                           if (hit && !busy) begin
                              state <= ST_ACK_WAIT;
                              to_tx <= byte_next[0];
                              kind  <= RX_REG;
                           end else begin
                              state <= ST_IDLE;
                           end
                        end
                        default: begin
                           state <= ST_ACK_WAIT;
                           to_tx <= 1'b0;
                           kind  <= RX_DATA;
                        end
                     endcase
                  end
               end
            end
            ST_ACK_WAIT: if (scl_f) state <= ST_ACK;
            ST_ACK: begin
               if (scl_f) begin
                  bitcnt <= '0;
                  if (to_tx) begin
                     shreg <= rd_data;
                     state <= ST_TX;
                  end else begin
                     state <= ST_RX;
                  end
               end
            end
            ST_TX: begin
               if (scl_r) bitcnt <= bitcnt + CW'(1);
               if (scl_f) begin
                  if (bitcnt == CW'(BITS)) state <= ST_MACK;
                  else                     shreg <= {shreg[6:0], 1'b0};
               end
            end
            ST_MACK: begin
               if (scl_r) state <= sda_l ? ST_IDLE : ST_MACK_HI;
            end
            ST_MACK_HI: begin
               if (scl_f) begin
                  shreg  <= rd_data;
                  bitcnt <= '0;
                  state  <= ST_TX;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign sda_oe = (state == ST_ACK) || ((state == ST_TX) && !shreg[7]);
endmodule

// File: rtl/i2cps_chk.sv
module i2cps_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_i,
   input logic sda_i,
   input logic sda_oe,
   input logic wr_en,
   input logic rd_en
);
   logic [2:0] age;
   logic       seen_start;
   logic       prev_sda;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         age        <= '0;
         seen_start <= 1'b0;
         prev_sda   <= 1'b1;
      end else begin
         if (age != 3'd7) age <= age + 3'd1;
         prev_sda <= sda_i;
         if (scl_i && prev_sda && !sda_i) seen_start <= 1'b1;
      end
   end

   AST_OE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (age >= 3'd5 && scl_i && $past(scl_i) && $past(scl_i, 2) && $past(scl_i, 3)
       && $past(scl_i, 4)) |-> $stable(sda_oe)); // R11

   AST_QUIET_BEFORE_START: assert property (@(posedge clk) disable iff (!rst_n)
      !seen_start |-> (!sda_oe && !wr_en && !rd_en)); // R10

   AST_WR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> !wr_en); // R4

   AST_RD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_en |=> !rd_en); // R6

   AST_WR_NOT_READING: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |-> !rd_en); // R4
endmodule

bind i2cps_slave i2cps_chk u_chk (
   .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
   .sda_oe(sda_oe), .wr_en(wr_en), .rd_en(rd_en)
);

// File: tb/i2cps_slave_bench.sv
module i2cps_slave_bench;
   localparam int CLK_PERIOD = 10;
   localparam int HALF       = 20;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #(CLK_PERIOD / 2) clk = ~clk;

   logic scl_m = 1'b1, sda_m = 1'b1, addr_sel = 1'b0, busy = 1'b0;
   logic sda_oe, wr_en, rd_en, sda_line;
   logic [7:0] reg_addr, wr_data, rd_data;
   logic [7:0] mem [256];
   logic [7:0] exp_mem [256];

   assign sda_line = sda_m & ~sda_oe;
   assign rd_data  = mem[reg_addr];

   i2cps_slave u_i2cps_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
      .addr_sel(addr_sel), .stored_addr(mem[0]), .busy(busy),
      .rd_data(rd_data), .sda_oe(sda_oe), .wr_en(wr_en), .rd_en(rd_en),
      .reg_addr(reg_addr), .wr_data(wr_data)
   );

   function automatic logic [7:0] init_val(int i);
      return (i == 0) ? 8'hA0 : (8'(i) ^ 8'h3C);
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < 256; i++) mem[i] <= init_val(i);
      end else if (wr_en) begin
         mem[reg_addr] <= wr_data;
      end
   end

   int  n_chk = 0, n_bad = 0, viol = 0;
   bit  reported = 0;
   logic [4:0] scl_hist = '0;
   logic prev_oe = 1'b0;

   // per-clock monitor of the data-line driver against the bus clock (R11)
   always @(negedge clk) begin
      if (rst_n) begin
         if ((&scl_hist) && scl_m && (sda_oe != prev_oe)) viol++;
      end
      scl_hist <= {scl_hist[3:0], scl_m};
      prev_oe  <= sda_oe;
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      if (!reported) begin
         reported = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic m_start();
      sda_m = 1'b1; scl_m = 1'b1; wclk(HALF);
      sda_m = 1'b0; wclk(HALF);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic m_rstart();
      sda_m = 1'b1; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      sda_m = 1'b0; wclk(HALF);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic m_stop();
      sda_m = 1'b0; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      sda_m = 1'b1; wclk(HALF);
   endtask

   task automatic m_wbyte(input logic [7:0] b, output bit ack);
      for (int i = 7; i >= 0; i--) begin
         sda_m = b[i]; wclk(HALF);
         scl_m = 1'b1; wclk(HALF);
         scl_m = 1'b0; wclk(4);
      end
      sda_m = 1'b1; wclk(HALF);
      scl_m = 1'b1; wclk(HALF / 2);
      ack = !sda_line;
      wclk(HALF / 2);
      scl_m = 1'b0; wclk(4);
   endtask

   task automatic m_rbyte(input bit mack, output logic [7:0] b);
      sda_m = 1'b1;
      b = '0;
      for (int i = 0; i < 8; i++) begin
         wclk(HALF);
         scl_m = 1'b1; wclk(HALF / 2);
         b = {b[6:0], sda_line};
         wclk(HALF / 2);
         scl_m = 1'b0; wclk(4);
      end
      sda_m = mack ? 1'b0 : 1'b1; wclk(HALF);
      scl_m = 1'b1; wclk(HALF);
      scl_m = 1'b0; wclk(4);
      sda_m = 1'b1;
   endtask

   // behavioural model of a write: bytes stay inside the aligned 2-byte row
   task automatic model_write(input int a, input logic [7:0] d[$]);
      int p = a;
      foreach (d[k]) begin
         exp_mem[p] = d[k];
         p = (p - (p % 2)) + ((p + 1) % 2);
      end
   endtask

   task automatic cmp_mem(input string tag);
      int bad = -1;
      for (int i = 0; i < 256; i++) if (bad < 0 && mem[i] !== exp_mem[i]) bad = i;
      if (bad < 0) chk(1'b1, tag, 0, 0);
      else         chk(1'b0, tag, mem[bad], exp_mem[bad]);
   endtask

   task automatic wr_txn(input logic [7:0] dev, input logic [7:0] a, input logic [7:0] d[$],
                         input string tag);
      bit ak, all_ok;
      m_start();
      m_wbyte(dev, ak); all_ok = ak;
      m_wbyte(a, ak);   all_ok &= ak;
      foreach (d[k]) begin m_wbyte(d[k], ak); all_ok &= ak; end
      m_stop();
      chk(all_ok, tag, all_ok, 1);
   endtask

   initial begin
      bit ak;
      logic [7:0] b;
      for (int i = 0; i < 256; i++) exp_mem[i] = init_val(i);
      wclk(5);
      // R10: reset state
      chk(!sda_oe && !wr_en && !rd_en, "R10", {sda_oe, wr_en, rd_en}, 0);
      rst_n = 1'b1;
      wclk(10);
      chk(!sda_oe && !wr_en && !rd_en, "R10", {sda_oe, wr_en, rd_en}, 0);

      // R1 / R4: fixed identity, single write
      m_start();
      m_wbyte(8'hA2, ak); chk(ak, "R1", ak, 1);
      m_wbyte(8'h10, ak); chk(ak, "R4", ak, 1);
      m_wbyte(8'h5A, ak); chk(ak, "R4", ak, 1);
      m_stop();
      model_write(8'h10, '{8'h5A});
      cmp_mem("R4");

      // R5: three bytes into the row at 0x12, then an odd start at 0x15
      wr_txn(8'hA2, 8'h12, '{8'h11, 8'h22, 8'h33}, "R5");
      model_write(8'h12, '{8'h11, 8'h22, 8'h33});
      chk(mem[8'h12] == 8'h33, "R5", mem[8'h12], 8'h33);
      wr_txn(8'hA2, 8'h15, '{8'h44, 8'h55}, "R5");
      model_write(8'h15, '{8'h44, 8'h55});
      chk(mem[8'h14] == 8'h55, "R5", mem[8'h14], 8'h55);
      cmp_mem("R5");

      // R6 / R7: positioned sequential read ending with NACK
      m_start();
      m_wbyte(8'hA2, ak);
      m_wbyte(8'h12, ak);
      m_rstart();
      m_wbyte(8'hA3, ak); chk(ak, "R6", ak, 1);
      m_rbyte(1'b1, b); chk(b == exp_mem[8'h12], "R6", b, exp_mem[8'h12]);
      m_rbyte(1'b1, b); chk(b == exp_mem[8'h13], "R6", b, exp_mem[8'h13]);
      m_rbyte(1'b0, b); chk(b == exp_mem[8'h14], "R6", b, exp_mem[8'h14]);
      wclk(8);
      chk(!sda_oe, "R7", sda_oe, 0);
      wclk(HALF); scl_m = 1'b1; wclk(HALF);
      chk(!sda_oe && sda_line, "R7", sda_line, 1);
      scl_m = 1'b0; wclk(4);
      m_stop();
      // R6: read with no positioning continues from the counter
      m_start();
      m_wbyte(8'hA3, ak);
      m_rbyte(1'b0, b); chk(b == exp_mem[8'h15], "R6", b, exp_mem[8'h15]);
      m_stop();

      // R8: rollover at the top of the space
      m_start();
      m_wbyte(8'hA2, ak);
      m_wbyte(8'hFF, ak);
      m_rstart();
      m_wbyte(8'hA3, ak);
      m_rbyte(1'b1, b); chk(b == exp_mem[8'hFF], "R8", b, exp_mem[8'hFF]);
      m_rbyte(1'b0, b); chk(b == exp_mem[8'h00], "R8", b, exp_mem[8'h00]);
      m_stop();

      // R3: foreign device byte, following bytes must be ignored
      m_start();
      m_wbyte(8'hA6, ak); chk(!ak, "R3", ak, 0);
      m_wbyte(8'h20, ak); chk(!ak, "R3", ak, 0);
      m_wbyte(8'h77, ak); chk(!ak, "R3", ak, 0);
      m_stop();
      cmp_mem("R3");

      // R2: stored identity 0x35 -> device 0x1A, bit 0 ignored
      wr_txn(8'hA2, 8'h00, '{8'h35}, "R2");
      model_write(8'h00, '{8'h35});
      addr_sel = 1'b1;
      wclk(4);
      m_start();
      m_wbyte(8'hA2, ak); chk(!ak, "R2", ak, 0);
      m_stop();
      wr_txn(8'h34, 8'h30, '{8'h99}, "R2");
      model_write(8'h30, '{8'h99});
      cmp_mem("R2");
      m_start();
      m_wbyte(8'h35, ak); chk(ak, "R2", ak, 1);
      m_rbyte(1'b0, b); chk(b == exp_mem[8'h31], "R2", b, exp_mem[8'h31]);
      m_stop();
      addr_sel = 1'b0;
      wclk(4);

      // R9: busy refuses the address
      busy = 1'b1;
      m_start();
      m_wbyte(8'hA2, ak); chk(!ak, "R9", ak, 0);
      m_wbyte(8'h40, ak);
      m_wbyte(8'h12, ak);
      m_stop();
      cmp_mem("R9");
      busy = 1'b0;
      m_start();
      m_wbyte(8'hA2, ak); chk(ak, "R9", ak, 1);
      m_stop();

      // R11: data line never moved while the bus clock was high
      chk(viol == 0, "R11", viol, 0);

      report();
      $finish;
   end

   initial begin
      repeat (180000) @(posedge clk);
      chk(1'b0, "watchdog", 0, 1);
      report();
      $finish;
   end
endmodule